// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory of 2K byte locations. It watches each port's chip select, write strobe and address. It reports a collision when both ports are selected and point at the same location. The port that formed its request first keeps access. The other port sees an active-low busy indication, and its write qualifier is held off, so a single location never takes two conflicting writes.

Arrival is counted in clock cycles. A port arrives in the cycle in which it becomes selected, or in which it changes to a new address while selected. The arbitration result is combinational from the current port inputs and a small amount of registered history, so busy and the write gating act in the same cycle as the collision. A mode input switches between two roles. In master operation the block decides the winner and drives the busy outputs. In slave operation the busy levels come from outside, and they only gate writes.

Top module: `port_collide_arbiter`

## Requirements
- R1: When the addresses differ, or either chip select (active low) is high, both busy outputs are high.
- R2: On a collision where one port's request was already present in an earlier cycle and the other port's request is new, the new port's busy goes low and the earlier port's busy stays high.
- R3: The two busy outputs are never low in the same cycle.
- R4: When both requests become new in the same cycle and collide, the right port's busy goes low and the left port's busy stays high.
- R5: A winning port keeps its grant for as long as its select and address are unchanged. The losing port's busy returns high in the same cycle that the collision ends.
- R6: In master mode, a port's write qualifier is high exactly when its chip select is low, its write strobe (active low) is low and its own busy output is high.
- R7: In master mode, both busy drive enables are high. In slave mode, both are low and both busy outputs read high.
- R8: In slave mode, a port's write qualifier is high exactly when its chip select is low, its write strobe is low and its external busy input is high. The internal arbitration has no effect on it.
- R9: When the winner drops its request and then returns to the same address while the other port has stayed unchanged, the port that stayed now wins and the returning port gets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 = busy taken from inputs, 0 = block arbitrates |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left address |
| l_busy_in_n | input | 1 | External left busy used in slave mode, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right address |
| r_busy_in_n | input | 1 | External right busy used in slave mode, active low |
| l_busy_n | output | 1 | Left busy, active low |
| l_busy_oe | output | 1 | Left busy drive enable |
| l_wr_en | output | 1 | Left internal write qualifier |
| r_busy_n | output | 1 | Right busy, active low |
| r_busy_oe | output | 1 | Right busy drive enable |
| r_wr_en | output | 1 | Right internal write qualifier |

## Verification
The assertions check the following on every cycle:
- the two busy outputs are never low together;
- no busy is raised without a collision;
- the write qualifiers follow the busy level that applies in each mode;
- the drive enables follow the mode;
- a held grant stays with its winner.

Which port wins depends on the order of arrival over several cycles, so only the bench's sequences show it. These cover first-left, first-right, simultaneous, hold, release and return orderings, swept over every address pair of a small address width.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_t;
endpackage

// File: rtl/req_track.sv
module req_track #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic [AW-1:0] addr,
   output logic          active,
   output logic          fresh
);
   logic          act_q;
   logic [AW-1:0] addr_q;

   assign active = !cs_n;
   // new request: selected now but not selected at this address last cycle
   assign fresh  = active && !(act_q && (addr_q == addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         act_q  <= active;
         addr_q <= addr;
      end
   end
endmodule

// File: rtl/collide_judge.sv
module collide_judge
   import arb_pkg::*;
#(
   parameter int AW       = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_act,
   input  logic          l_fresh,
   input  logic [AW-1:0] l_addr,
   input  logic          r_act,
   input  logic          r_fresh,
   input  logic [AW-1:0] r_addr,
   output own_t          owner
);
   own_t owner_q;
   own_t tie_winner;
   logic match;
   logic held;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_winner = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_winner = OWN_RIGHT;
      end
   endgenerate

   assign match = l_act && r_act && (l_addr == r_addr);
   assign held  = ((owner_q == OWN_LEFT)  && !l_fresh) ||
                  ((owner_q == OWN_RIGHT) && !r_fresh);

   always_comb begin
      if (!match)                 owner = OWN_NONE;
      else if (held)              owner = owner_q;
      else if (l_fresh && !r_fresh) owner = OWN_RIGHT;
      else if (r_fresh && !l_fresh) owner = OWN_LEFT;
      else                        owner = tie_winner;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner;
   end

   // R5: a held winner is not displaced while its request is unchanged
   assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_LEFT && l_act && r_act && l_addr == r_addr && !l_fresh)
         |-> owner == OWN_LEFT);
   assert_no_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_act || !r_act) |-> owner == OWN_NONE);
endmodule

// File: rtl/port_gate.sv
module port_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic slave_mode,
   input  logic cs_n,
   input  logic we_n,
   input  logic lose,
   input  logic busy_in_n,
   output logic busy_n,
   output logic busy_oe,
   output logic wr_en
);
   logic blocked;

   assign busy_n  = slave_mode ? 1'b1 : !lose;
   assign busy_oe = !slave_mode;
   assign blocked = slave_mode ? !busy_in_n : lose;
   assign wr_en   = !cs_n && !we_n && !blocked;

   assert_master_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && !busy_n) |-> !wr_en);
   assert_slave_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && !busy_in_n) |-> !wr_en);
   assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_oe != slave_mode);
endmodule

// File: rtl/port_collide_arbiter.sv
module port_collide_arbiter
   import arb_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode,
   input  logic              l_cs_n,
   input  logic              l_we_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy_in_n,
   input  logic              r_cs_n,
   input  logic              r_we_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy_in_n,
   output logic              l_busy_n,
   output logic              l_busy_oe,
   output logic              l_wr_en,
   output logic              r_busy_n,
   output logic              r_busy_oe,
   output logic              r_wr_en
);
   localparam int NPORT = 2;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_v   [NPORT];
   logic [NPORT-1:0]  cs_v, we_v, bin_v, act_v, fresh_v, lose_v;
   logic [NPORT-1:0]  busy_v, oe_v, wr_v;
   own_t              owner;

   assign addr_v[0] = l_addr;
   assign addr_v[1] = r_addr;
   assign cs_v      = {r_cs_n, l_cs_n};
   assign we_v      = {r_we_n, l_we_n};
   assign bin_v     = {r_busy_in_n, l_busy_in_n};
   assign lose_v    = {owner == OWN_LEFT, owner == OWN_RIGHT};

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         req_track #(.AW(ADDR_W)) u_track (
            .clk(clk), .rst_n(rst_n), .cs_n(cs_v[p]), .addr(addr_v[p]),
            .active(act_v[p]), .fresh(fresh_v[p]));
         port_gate u_gate (
            .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
            .cs_n(cs_v[p]), .we_n(we_v[p]), .lose(lose_v[p]),
            .busy_in_n(bin_v[p]), .busy_n(busy_v[p]), .busy_oe(oe_v[p]),
            .wr_en(wr_v[p]));
      end
   endgenerate

   collide_judge #(.AW(ADDR_W), .TIE_LEFT(TIE_LEFT)) u_judge (
      .clk(clk), .rst_n(rst_n),
      .l_act(act_v[0]), .l_fresh(fresh_v[0]), .l_addr(addr_v[0]),
      .r_act(act_v[1]), .r_fresh(fresh_v[1]), .r_addr(addr_v[1]),
      .owner(owner));

   assign l_busy_n  = busy_v[0];
   assign r_busy_n  = busy_v[1];
   assign l_busy_oe = oe_v[0];
   assign r_busy_oe = oe_v[1];
   assign l_wr_en   = wr_v[0];
   assign r_wr_en   = wr_v[1];

   assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy_n || r_busy_n);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (l_cs_n || r_cs_n || l_addr != r_addr) |-> (l_busy_n && r_busy_n));
endmodule

// File: tb/port_collide_arbiter_tb.sv
module port_collide_arbiter_tb;
   localparam int AW = 3;
   localparam int NA = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slave_mode = 1'b0;
   logic l_cs_n = 1'b1, l_we_n = 1'b1, l_busy_in_n = 1'b1;
   logic r_cs_n = 1'b1, r_we_n = 1'b1, r_busy_in_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_busy_n, l_busy_oe, l_wr_en, r_busy_n, r_busy_oe, r_wr_en;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   port_collide_arbiter #(.ADDR_W(AW)) u_dut (.*);

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic drive(input logic lc, input logic lw, input int la,
                        input logic rc, input logic rw, input int ra);
      @(posedge clk); #1;
      l_cs_n = lc; l_we_n = lw; l_addr = AW'(la);
      r_cs_n = rc; r_we_n = rw; r_addr = AW'(ra);
      #1;
   endtask

   task automatic chk(input string req, input logic lb, input logic rb,
                      input logic lw, input logic rw);
      logic [5:0] act, exp;
      logic eo;
      eo  = !slave_mode;
      act = {l_busy_n, r_busy_n, l_wr_en, r_wr_en, l_busy_oe, r_busy_oe};
      exp = {lb, rb, lw, rw, eo, eo};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (lb rb lw rw loe roe)", req, act, exp);
      end
      checks++;
      if (!l_busy_n && !r_busy_n) begin
         errors++;
         $display("FAIL R3: got both busy low, expected at most one");
      end
   endtask

   initial begin
      logic m;
      #1; #3;
      chk("R1 reset", 1, 1, 0, 0);
      #6 rst_n = 1'b1;
      for (int la = 0; la < NA; la++) begin
         for (int ra = 0; ra < NA; ra++) begin
            m = (la == ra);
            drive(1, 1, 0, 1, 1, 0);   chk("R1 idle", 1, 1, 0, 0);
            drive(0, 0, la, 1, 1, ra); chk("R6 left alone", 1, 1, 1, 0);
            drive(0, 0, la, 0, 0, ra); chk("R2 right later", 1, !m, 1, !m);
            drive(1, 0, la, 0, 0, ra); chk("R5 release", 1, 1, 0, 1);
            drive(0, 0, la, 0, 0, ra); chk("R9 return", !m, 1, !m, 1);
            drive(0, 1, la, 0, 0, ra); chk("R9 hold", !m, 1, 0, 1);
            drive(1, 1, 0, 1, 1, 0);   chk("R1 idle2", 1, 1, 0, 0);
            drive(0, 0, la, 0, 0, ra); chk("R4 tie", 1, !m, 1, !m);
            drive(0, 0, la, 0, 1, ra); chk("R5 hold", 1, !m, 1, 0);
            drive(1, 1, 0, 1, 1, 0);
            drive(1, 1, 0, 0, 0, ra);  chk("R6 right alone", 1, 1, 0, 1);
            drive(0, 0, la, 0, 0, ra); chk("R2 left later", !m, 1, !m, 1);
            drive(1, 1, 0, 1, 1, 0);
         end
      end
      // slave mode: same-address collision, busy taken from inputs
      slave_mode = 1'b1;
      for (int b = 0; b < 4; b++) begin
         drive(1, 1, 0, 1, 1, 0);
         @(posedge clk); #1;
         l_busy_in_n = b[0]; r_busy_in_n = b[1];
         l_cs_n = 0; l_we_n = 0; r_cs_n = 0; r_we_n = 0; l_addr = 3; r_addr = 3;
         #1;
         chk("R8 slave gate", 1, 1, b[0], b[1]);
         drive(0, 0, 3, 0, 0, 3);
         chk("R7 slave drive", 1, 1, b[0], b[1]);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule